// File: doc/BRIEF.md
# Variable-Page Fully Associative Translation Buffer

This block translates a virtual address into a physical address by comparing it, all at once, against every entry of a small fully associative table. Each entry pairs a tag with a translation word. The tag holds a virtual page number and an address-space context. The translation word holds a frame number, a two-bit page-size code, and valid, privileged-only, writable and locked flags. The size code sets how many low address bits each entry ignores, so pages from 8 KB to 4 MB can share one table. A table walker, which lies outside this block, fills the table through an indexed load port.

A lookup request carries the virtual address, a write flag and a user flag. It is accepted on a valid/ready handshake and captured in a request register, together with the current context and the translation-enable input. One cycle later the response holds exactly one of three outcomes:

- **hit**, with the physical address, read and write permission and the locked flag;
- **miss**, when no entry matches;
- **protection fault**, when an entry matches but the access is not allowed.

The response stays valid, and the block takes no new request, until `rsp_ready` is high. A request is accepted whenever `req_ready` is high at a clock edge. `req_ready` is high when the response slot is empty or is being consumed in that same cycle.

A fault status register and a fault address register record protection faults when their response is accepted. The parameter `FETCH_MODE` builds the same block for instruction fetch. In that variant writes are never checked or granted, and the fault address is not recorded.

Top module: `varpage_tlb`

## Requirements
- R1: When the captured enable is 0, the response is a hit with `rsp_pa` equal to the virtual address and read allowed. Write is allowed in the data variant and refused in the fetch variant. `rsp_locked` is 0.
- R2: Translation word bits 62:61 give the page size: 0 is 8 KB, 1 is 64 KB, 2 is 512 KB and 3 is 4 MB. Only address bits at and above position 13+3*size take part in the compare.
- R3: An entry matches only when tag bits 12:0 equal the captured context, and the masked address equals the tag with bits 12:0 cleared. A tag bit set inside the page therefore prevents any match.
- R4: When several entries match, the one with the lowest index decides the outcome.
- R5: When no entry matches, the response is a miss with `rsp_pa` 0. Fault status and fault address stay unchanged.
- R6: A matching entry faults in any of these cases:
  - its bit 63 (valid) is 0;
  - its bit 2 (privileged) is 1 and the access is a user access;
  - in the data variant only, the access is a write and its bit 1 (writable) is 0.

  A fault reports `rsp_pa` 0. The fetch variant ignores `req_write`.
- R7: On a hit, `rsp_pa` is built as follows:
  - bits 40:12 above the page mask come from the translation word;
  - bits 40:12 below the page mask come from the virtual address;
  - bits 11:0 come from the virtual address;
  - all bits above 40 are 0.
- R8: On a hit, `rsp_rd_ok` is 1. `rsp_wr_ok` equals bit 1 in the data variant and is 0 in the fetch variant. `rsp_locked` reports bit 6 of any matched entry.
- R9: When a fault response is accepted, the status register is first set to 2 if it was non-zero. It then has (user<<3) | (write<<2) | 1 ORed in, with write forced to 0 in the fetch variant.
- R10: When a fault response is accepted in the data variant, the fault address register takes the faulting virtual address. The fetch variant never changes it.
- R11: `fsr_clear` zeroes the status register at the next edge. If a fault response is accepted in the same cycle, the status takes that fault's value as if it had been 0.
- R12: `req_ready` is 1 when `rsp_valid` is 0 or `rsp_ready` is 1. A request accepted at an edge gives `rsp_valid` after that edge. The response and `rsp_pa` hold while `rsp_ready` is 0.
- R13: After reset, every entry holds an all-zero tag and translation word. A load at an edge is seen by lookups responding after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation enable, captured with each request |
| ctx | input | 13 | Current context, captured with each request |
| fsr_clear | input | 1 | Clears the fault status register |
| ld_en | input | 1 | Load strobe for one entry |
| ld_idx | input | 6 | Entry index to load |
| ld_tag | input | 64 | Tag: virtual page in 63:13, context in 12:0 |
| ld_tte | input | 64 | Translation word |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be accepted |
| req_va | input | 64 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No entry matched |
| rsp_fault | output | 1 | Protection fault |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |
| rsp_locked | output | 1 | Matched entry is locked |
| rsp_pa | output | 64 | Physical address |
| fsr | output | 4 | Fault status register |
| far | output | 64 | Fault address register |

## Verification
A corrupted stored field shows at the ports on the first lookup that matches the entry, one cycle after that request is accepted. It appears as the wrong outcome or as wrong `rsp_pa` bits. A fault in the priority selection appears only when two entries overlap, so overlapping tags are built on purpose. A fault in the status logic appears on `fsr` or `far` one cycle after a response handshake. An overflow error only shows on the second fault without a clear in between, so fault sequences are chained. A stuck request register shows as a response that does not hold under back-pressure, or as a ready that ignores the response slot.

// File: rtl/vpt_pkg.sv
package vpt_pkg;
  // Field positions in the translation word that the lookup logic decodes
  localparam int TTE_VALID_BIT = 63;
  localparam int TTE_SIZE_HI   = 62;
  localparam int TTE_SIZE_LO   = 61;
  localparam int TTE_LOCK_BIT  = 6;
  localparam int TTE_PRIV_BIT  = 2;
  localparam int TTE_WRT_BIT   = 1;

  // Smallest page is 2**13 bytes; each size step multiplies by 8
  localparam int PAGE_SHIFT_MIN = 13;
  localparam int SIZE_STEP      = 3;
  localparam int OFFS_W         = 12;

  localparam logic [3:0] FSR_OVERFLOW = 4'd2;

  typedef struct packed {
    logic       valid;
    logic [1:0] size;
    logic       priv;
    logic       wrt;
    logic       lock;
  } tte_attr_t;

  // Extra bits the size code removes from the compare, above the minimum page
  function automatic int unsigned size_extra(input logic [1:0] sz);
    return SIZE_STEP * int'(sz);
  endfunction

  function automatic int unsigned page_shift(input logic [1:0] sz);
    return PAGE_SHIFT_MIN + size_extra(sz);
  endfunction
endpackage

// File: rtl/vpt_entry_array.sv
module vpt_entry_array
  import vpt_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 64,
  parameter int CTX_W   = 13,
  parameter int PA_HI   = 40,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_en,
  input  logic [IDX_W-1:0]           ld_idx,
  input  logic [VA_W-1:0]            ld_tag,
  input  logic [63:0]                ld_tte,
  input  logic [VA_W-1:0]            look_va,
  input  logic [CTX_W-1:0]           look_ctx,
  output logic [ENTRIES-1:0]         match_vec,
  input  logic [IDX_W-1:0]           rd_idx,
  output tte_attr_t                  rd_attr,
  output logic [PA_HI:PAGE_SHIFT_MIN] rd_pfn
);
  localparam int VPN_W = VA_W - PAGE_SHIFT_MIN;

  logic [VA_W-1:PAGE_SHIFT_MIN]  vpn_q  [ENTRIES];
  logic [CTX_W-1:0]              ctx_q  [ENTRIES];
  tte_attr_t                     attr_q [ENTRIES];
  logic [PA_HI:PAGE_SHIFT_MIN]   pfn_q  [ENTRIES];

  tte_attr_t ld_attr;
  assign ld_attr = '{valid: ld_tte[TTE_VALID_BIT],
                     size:  ld_tte[TTE_SIZE_HI:TTE_SIZE_LO],
                     priv:  ld_tte[TTE_PRIV_BIT],
                     wrt:   ld_tte[TTE_WRT_BIT],
                     lock:  ld_tte[TTE_LOCK_BIT]};

  // Word bits that carry no meaning for translation
  logic unused_tte_bits;
  assign unused_tte_bits = ^{ld_tte[TTE_SIZE_LO-1:PA_HI+1], ld_tte[PAGE_SHIFT_MIN-1:TTE_LOCK_BIT+1],
                             ld_tte[TTE_LOCK_BIT-1:TTE_PRIV_BIT+1], ld_tte[0]};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vpn_q[g]  <= '0;
        ctx_q[g]  <= '0;
        attr_q[g] <= '0;
        pfn_q[g]  <= '0;
      end else if (ld_en && ld_idx == IDX_W'(g)) begin
        vpn_q[g]  <= ld_tag[VA_W-1:PAGE_SHIFT_MIN];
        ctx_q[g]  <= ld_tag[CTX_W-1:0];
        attr_q[g] <= ld_attr;
        pfn_q[g]  <= ld_tte[PA_HI:PAGE_SHIFT_MIN];
      end
    end

    // Compare mask over the page-number bits only
    logic [VA_W-1:PAGE_SHIFT_MIN] cmp_mask;
    assign cmp_mask = {VPN_W{1'b1}} << size_extra(attr_q[g].size);
    assign match_vec[g] = (ctx_q[g] == look_ctx) &&
                          ((look_va[VA_W-1:PAGE_SHIFT_MIN] & cmp_mask) == vpn_q[g]);
  end

  assign rd_attr = attr_q[rd_idx];
  assign rd_pfn  = pfn_q[rd_idx];
endmodule

// File: rtl/vpt_first_match.sv
module vpt_first_match #(
  parameter int N      = 64,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     vec,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
  assign any = |vec;

  // R4: the chosen entry matches and no lower entry does
  a_r4_lowest_index: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (vec[idx] && ((vec & ((N'(1) << idx) - N'(1))) == '0)));
endmodule

// File: rtl/vpt_fault_log.sv
module vpt_fault_log
  import vpt_pkg::*;
#(
  parameter int VA_W       = 64,
  parameter bit FETCH_MODE = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            fault_fire,
  input  logic            f_user,
  input  logic            f_write,
  input  logic [VA_W-1:0] f_va,
  output logic [3:0]      fsr,
  output logic [VA_W-1:0] far
);
  logic [3:0] fsr_q, fsr_base, fsr_nxt;

  always_comb begin
    fsr_base = clear ? 4'd0 : fsr_q;
    fsr_nxt  = fsr_base;
    if (fault_fire) begin
      fsr_nxt = (fsr_base != 4'd0) ? FSR_OVERFLOW : 4'd0;
      fsr_nxt = fsr_nxt | {f_user, f_write, 1'b0, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fsr_q <= '0;
    else        fsr_q <= fsr_nxt;
  end
  assign fsr = fsr_q;

  if (FETCH_MODE) begin : g_far_fetch
    assign far = '0;
    logic unused_far_in;
    assign unused_far_in = ^f_va;
  end else begin : g_far_data
    logic [VA_W-1:0] far_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          far_q <= '0;
      else if (fault_fire) far_q <= f_va;
    end
    assign far = far_q;

    a_r10_far_latch: assert property (@(posedge clk) disable iff (!rst_n)
      fault_fire |=> far == $past(f_va));
  end

  a_r9_fault_marks: assert property (@(posedge clk) disable iff (!rst_n)
    fault_fire |=> fsr[0]);
  a_r9_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_fire && !clear && fsr != 4'd0) |=> fsr[1]);
  a_r5_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_fire && !clear) |=> $stable(fsr) && $stable(far));
  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !fault_fire) |=> fsr == 4'd0);
endmodule

// File: rtl/varpage_tlb.sv
module varpage_tlb
  import vpt_pkg::*;
#(
  parameter int ENTRIES    = 64,
  parameter int VA_W       = 64,
  parameter int CTX_W      = 13,
  parameter int PA_HI      = 40,
  parameter bit FETCH_MODE = 1'b0,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xlate_en,
  input  logic [CTX_W-1:0] ctx,
  input  logic             fsr_clear,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [VA_W-1:0]  ld_tag,
  input  logic [63:0]      ld_tte,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic             req_write,
  input  logic             req_user,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic             rsp_rd_ok,
  output logic             rsp_wr_ok,
  output logic             rsp_locked,
  output logic [VA_W-1:0]  rsp_pa,
  output logic [3:0]       fsr,
  output logic [VA_W-1:0]  far
);
  localparam logic [VA_W-1:0] ONE        = VA_W'(1);
  localparam logic [VA_W-1:0] FRAME_MASK = ((ONE << (PA_HI + 1)) - ONE) & ~((ONE << OFFS_W) - ONE);
  localparam logic [VA_W-1:0] OFFS_MASK  = (ONE << OFFS_W) - ONE;

  // ---------------- request register ----------------
  logic             v_q, en_q, wr_q, usr_q;
  logic [VA_W-1:0]  va_q;
  logic [CTX_W-1:0] ctx_q;
  logic             accept, fire;

  assign req_ready = !v_q || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign fire      = v_q && rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      en_q  <= 1'b0;
      wr_q  <= 1'b0;
      usr_q <= 1'b0;
      va_q  <= '0;
      ctx_q <= '0;
    end else begin
      if (req_ready) v_q <= req_valid;
      if (accept) begin
        en_q  <= xlate_en;
        wr_q  <= req_write;
        usr_q <= req_user;
        va_q  <= req_va;
        ctx_q <= ctx;
      end
    end
  end
  assign rsp_valid = v_q;

  // Write check and write grant exist only in the data variant
  logic chk_write, grant_write;
  if (FETCH_MODE) begin : g_fetch
    assign chk_write   = 1'b0;
    assign grant_write = 1'b0;
    logic unused_wr;
    assign unused_wr = wr_q;
  end else begin : g_data
    assign chk_write   = wr_q;
    assign grant_write = 1'b1;
  end

  // ---------------- associative search ----------------
  logic [ENTRIES-1:0]          match_vec;
  logic                        any_match;
  logic [IDX_W-1:0]            sel_idx;
  tte_attr_t                   sel_attr;
  logic [PA_HI:PAGE_SHIFT_MIN] sel_pfn;

  vpt_entry_array #(
    .ENTRIES(ENTRIES), .VA_W(VA_W), .CTX_W(CTX_W), .PA_HI(PA_HI)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_tag(ld_tag), .ld_tte(ld_tte),
    .look_va(va_q), .look_ctx(ctx_q),
    .match_vec(match_vec),
    .rd_idx(sel_idx), .rd_attr(sel_attr), .rd_pfn(sel_pfn)
  );

  vpt_first_match #(.N(ENTRIES)) u_prio (
    .clk(clk), .rst_n(rst_n), .vec(match_vec), .any(any_match), .idx(sel_idx)
  );

  // ---------------- outcome and address ----------------
  logic [VA_W-1:0] page_mask, frame_base, xl_pa;
  logic            bad;

  assign page_mask  = {VA_W{1'b1}} << page_shift(sel_attr.size);
  assign frame_base = VA_W'({sel_pfn, {PAGE_SHIFT_MIN{1'b0}}});
  assign xl_pa      = (frame_base & page_mask & FRAME_MASK) |
                      (va_q & ~page_mask & FRAME_MASK) |
                      (va_q & OFFS_MASK);
  assign bad        = !sel_attr.valid || (sel_attr.priv && usr_q) ||
                      (chk_write && !sel_attr.wrt);

  always_comb begin
    rsp_hit    = 1'b0;
    rsp_miss   = 1'b0;
    rsp_fault  = 1'b0;
    rsp_rd_ok  = 1'b0;
    rsp_wr_ok  = 1'b0;
    rsp_locked = 1'b0;
    rsp_pa     = '0;
    if (!en_q) begin
      rsp_hit   = 1'b1;
      rsp_rd_ok = 1'b1;
      rsp_wr_ok = grant_write;
      rsp_pa    = va_q;
    end else if (any_match) begin
      rsp_locked = sel_attr.lock;
      rsp_fault  = bad;
      rsp_hit    = !bad;
      rsp_rd_ok  = !bad;
      rsp_wr_ok  = !bad && grant_write && sel_attr.wrt;
      rsp_pa     = bad ? '0 : xl_pa;
    end else begin
      rsp_miss = 1'b1;
    end
  end

  vpt_fault_log #(.VA_W(VA_W), .FETCH_MODE(FETCH_MODE)) u_flog (
    .clk(clk), .rst_n(rst_n), .clear(fsr_clear),
    .fault_fire(fire && rsp_fault), .f_user(usr_q), .f_write(chk_write), .f_va(va_q),
    .fsr(fsr), .far(far)
  );

  // ---------------- assertions ----------------
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(va_q) && $stable(en_q)));
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_miss, rsp_fault}));
  a_r8_write_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_wr_ok) |-> (rsp_hit && rsp_rd_ok));
  a_r7_pa_width: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && en_q && rsp_hit) |-> ((rsp_pa & ~((ONE << (PA_HI + 1)) - ONE)) == '0));
endmodule

// File: tb/varpage_tlb_tb.sv
`timescale 1ns/1ps
module varpage_tlb_tb;
  typedef struct packed {
    logic hit, miss, fault, rd, wr, lock;
    logic [63:0] pa;
  } res_t;

  localparam logic [63:0] FRAME = 64'h0000_01FF_FFFF_F000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b1;
  logic [12:0] ctx = '0;
  logic        fsr_clear = 1'b0;
  logic        ld_en = 1'b0;
  logic [5:0]  ld_idx = '0;
  logic [63:0] ld_tag = '0, ld_tte = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [63:0] req_va = '0;
  logic        rsp_ready = 1'b1;

  logic        d_req_ready, d_rsp_valid, d_hit, d_miss, d_fault, d_rd, d_wr, d_lock;
  logic [63:0] d_pa, d_far;
  logic [3:0]  d_fsr;
  logic        f_req_ready, f_rsp_valid, f_hit, f_miss, f_fault, f_rd, f_wr, f_lock;
  logic [63:0] f_pa, f_far;
  logic [3:0]  f_fsr;

  varpage_tlb #(.FETCH_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .ctx(ctx), .fsr_clear(fsr_clear),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_tag(ld_tag), .ld_tte(ld_tte),
    .req_valid(req_valid), .req_ready(d_req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(d_rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(d_hit), .rsp_miss(d_miss),
    .rsp_fault(d_fault), .rsp_rd_ok(d_rd), .rsp_wr_ok(d_wr), .rsp_locked(d_lock),
    .rsp_pa(d_pa), .fsr(d_fsr), .far(d_far));

  varpage_tlb #(.FETCH_MODE(1'b1)) u_dut_fetch (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .ctx(ctx), .fsr_clear(fsr_clear),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_tag(ld_tag), .ld_tte(ld_tte),
    .req_valid(req_valid), .req_ready(f_req_ready), .req_va(req_va),
    .req_write(req_write), .req_user(req_user),
    .rsp_valid(f_rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(f_hit), .rsp_miss(f_miss),
    .rsp_fault(f_fault), .rsp_rd_ok(f_rd), .rsp_wr_ok(f_wr), .rsp_locked(f_lock),
    .rsp_pa(f_pa), .fsr(f_fsr), .far(f_far));

  int vectors = 0;
  int miscompares = 0;

  logic [63:0] m_tag [64];
  logic [63:0] m_tte [64];
  logic [3:0]  m_fsr_d = '0, m_fsr_f = '0;
  logic [63:0] m_far_d = '0, m_far_f = '0;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] size_mask(input logic [1:0] sz);
    return ~64'h0 << (13 + 3 * int'(sz));
  endfunction

  // Reference translation computed from the requirements (R1..R8)
  function automatic res_t ref_lookup(input logic [63:0] va, input logic [12:0] c,
                                      input bit en, input bit wr, input bit usr, input bit fetch);
    res_t r;
    r = '0;
    if (!en) begin
      r.hit = 1'b1; r.rd = 1'b1; r.wr = !fetch; r.pa = va;
      return r;
    end
    for (int i = 0; i < 64; i++) begin
      logic [63:0] mk;
      bit bad;
      mk = size_mask(m_tte[i][62:61]);
      if (m_tag[i][12:0] == c && (va & mk) == (m_tag[i] & ~64'h1FFF)) begin
        bad = !m_tte[i][63] || (m_tte[i][2] && usr) || (!fetch && wr && !m_tte[i][1]);
        r.lock = m_tte[i][6];
        r.fault = bad; r.hit = !bad; r.rd = !bad;
        r.wr = !bad && !fetch && m_tte[i][1];
        if (!bad) r.pa = (m_tte[i] & mk & FRAME) | (va & ~mk & FRAME) | (va & 64'hFFF);
        return r;
      end
    end
    r.miss = 1'b1;
    return r;
  endfunction

  function automatic logic [3:0] next_fsr(input logic [3:0] cur, input bit clr, input bit flt,
                                          input bit usr, input bit wr);
    logic [3:0] b;
    b = clr ? 4'd0 : cur;
    if (flt) begin
      b = (b != 0) ? 4'd2 : 4'd0;
      b = b | {usr, wr, 1'b0, 1'b1};
    end
    return b;
  endfunction

  // R13: entry load, visible to the next lookup
  task automatic load(input int idx, input logic [63:0] tag, input logic [63:0] tte);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = 6'(idx); ld_tag = tag; ld_tte = tte;
    @(posedge clk);
    m_tag[idx] = tag; m_tte[idx] = tte;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic do_lookup(input string rq, input logic [63:0] va, input bit wr, input bit usr,
                           input bit clr, input bit chk_pa, input logic [63:0] want_pa);
    res_t ed, ef;
    @(negedge clk);
    req_va = va; req_write = wr; req_user = usr; req_valid = 1'b1;
    ed = ref_lookup(va, ctx, xlate_en, wr, usr, 1'b0);
    ef = ref_lookup(va, ctx, xlate_en, wr, usr, 1'b1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    fsr_clear = clr;
    chk(rq, "data valid", 64'(d_rsp_valid), 64'd1);
    chk(rq, "data flags", 64'({d_hit, d_miss, d_fault, d_rd, d_wr, d_lock}),
        64'({ed.hit, ed.miss, ed.fault, ed.rd, ed.wr, ed.lock}));
    chk(rq, "data pa", d_pa, ed.pa);
    chk(rq, "fetch flags", 64'({f_hit, f_miss, f_fault, f_rd, f_wr, f_lock}),
        64'({ef.hit, ef.miss, ef.fault, ef.rd, ef.wr, ef.lock}));
    chk(rq, "fetch pa", f_pa, ef.pa);
    if (chk_pa) chk(rq, "data pa fixed", d_pa, want_pa);
    @(posedge clk);
    m_fsr_d = next_fsr(m_fsr_d, clr, ed.fault, usr, wr);
    m_fsr_f = next_fsr(m_fsr_f, clr, ef.fault, usr, 1'b0);
    if (ed.fault) m_far_d = va;
    @(negedge clk);
    fsr_clear = 1'b0;
    chk("R9", "data fsr", 64'(d_fsr), 64'(m_fsr_d));
    chk("R9", "fetch fsr", 64'(f_fsr), 64'(m_fsr_f));
    chk("R10", "data far", d_far, m_far_d);
    chk("R10", "fetch far", f_far, m_far_f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [63:0] held_pa;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin m_tag[i] = '0; m_tte[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R12 handshake idle, R9/R10 registers clear)
    chk("R12", "reset req_ready", 64'(d_req_ready), 64'd1);
    chk("R12", "reset rsp_valid", 64'(d_rsp_valid), 64'd0);
    chk("R9", "reset fsr", 64'(d_fsr), 64'd0);
    chk("R10", "reset far", d_far, 64'd0);

    // R13: zeroed entries match context 0, page 0 and fault as invalid
    ctx = 13'd0;
    do_lookup("R13", 64'h0000_0000_0000_1234, 1'b0, 1'b1, 1'b0, 1'b0, '0);

    ctx = 13'd5;
    // 8 KB page, writable, locked
    load(10, 64'h0000_0000_1234_6000 | 64'd5, 64'h8000_0001_5555_4042);
    do_lookup("R7", 64'h0000_0000_1234_7ABC, 1'b1, 1'b1, 1'b0, 1'b1, 64'h0000_0001_5555_5ABC);
    // 4 MB page
    load(20, 64'h0000_0000_8040_0000 | 64'd5, 64'hE000_0001_2340_0002);
    do_lookup("R2", 64'h0000_0000_805F_1234, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0000_0001_235F_1234);
    // two matching 64 KB entries: lower index wins
    load(40, 64'h0000_0000_0777_0000 | 64'd5, 64'hA000_0000_0CD0_0002);
    load(30, 64'h0000_0000_0777_0000 | 64'd5, 64'hA000_0000_0AB0_0002);
    do_lookup("R4", 64'h0000_0000_0777_5678, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0000_0000_0AB0_5678);
    // 512 KB page: last byte inside and first byte past it
    load(45, 64'h0000_0000_0100_0000 | 64'd5, 64'hC000_0000_3000_0000);
    do_lookup("R2", 64'h0000_0000_0107_FFFF, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0000_0000_3007_FFFF);
    do_lookup("R5", 64'h0000_0000_0108_0000, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0);
    // context mismatch
    ctx = 13'd6;
    do_lookup("R3", 64'h0000_0000_1234_7ABC, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    ctx = 13'd5;
    // tag bit inside a 64 KB page prevents a match
    load(46, 64'h0000_0000_0900_2000 | 64'd5, 64'hA000_0000_0600_0002);
    do_lookup("R3", 64'h0000_0000_0900_2000, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    // privileged page
    load(50, 64'h0000_0000_0200_0000 | 64'd5, 64'h8000_0000_4000_0006);
    do_lookup("R6", 64'h0000_0000_0200_0010, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    do_lookup("R6", 64'h0000_0000_0200_0010, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    // read-only page: data write faults, fetch variant ignores the write
    load(51, 64'h0000_0000_0200_2000 | 64'd5, 64'h8000_0000_4000_2000);
    do_lookup("R6", 64'h0000_0000_0200_2020, 1'b1, 1'b1, 1'b0, 1'b0, '0);
    do_lookup("R8", 64'h0000_0000_0200_2020, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    // invalid entry faults rather than misses
    load(52, 64'h0000_0000_0200_4000 | 64'd5, 64'h0000_0000_4000_4002);
    do_lookup("R6", 64'h0000_0000_0200_4000, 1'b0, 1'b0, 1'b0, 1'b0, '0);
    // frame bits above 40 are dropped
    load(53, 64'h0000_0000_0200_6000 | 64'd5, 64'h9FFF_FE00_5000_0000);
    do_lookup("R7", 64'h0000_0000_0200_6123, 1'b0, 1'b0, 1'b0, 1'b1, 64'h0000_0000_5000_0123);
    // pass-through
    xlate_en = 1'b0;
    do_lookup("R1", 64'hFFFF_0000_1234_5678, 1'b1, 1'b1, 1'b0, 1'b1, 64'hFFFF_0000_1234_5678);
    xlate_en = 1'b1;
    // R11: plain clear, then clear together with a fault
    @(negedge clk); fsr_clear = 1'b1;
    @(posedge clk); m_fsr_d = 4'd0; m_fsr_f = 4'd0;
    @(negedge clk); fsr_clear = 1'b0;
    chk("R11", "cleared fsr", 64'(d_fsr), 64'd0);
    chk("R11", "cleared fetch fsr", 64'(f_fsr), 64'd0);
    do_lookup("R9", 64'h0000_0000_0200_0010, 1'b1, 1'b1, 1'b0, 1'b0, '0);
    do_lookup("R11", 64'h0000_0000_0200_4000, 1'b0, 1'b0, 1'b1, 1'b0, '0);

    // R12: back-pressure holds the response and blocks new requests
    @(negedge clk);
    rsp_ready = 1'b0; req_va = 64'h0000_0000_1234_6010; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R12", "valid under stall", 64'(d_rsp_valid), 64'd1);
    chk("R12", "ready under stall", 64'(d_req_ready), 64'd0);
    held_pa = d_pa;
    chk("R12", "stalled pa", held_pa, 64'h0000_0001_5555_4010);
    req_va = 64'h0000_0000_0777_0000;
    @(posedge clk);
    @(negedge clk);
    chk("R12", "pa held", d_pa, held_pa);
    rsp_ready = 1'b1; req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R12", "drained", 64'(d_rsp_valid), 64'd0);

    // random table and random lookups
    for (int i = 0; i < 64; i++) begin
      logic [1:0]  sz;
      logic [63:0] tag, tte;
      sz  = 2'($urandom % 4);
      tag = ({$urandom, $urandom} & size_mask(sz) & 64'h0000_0000_3FFF_E000) | 64'($urandom % 3);
      tte = {$urandom, $urandom};
      tte[62:61] = sz;
      tte[63] = ($urandom % 10) != 0;
      load(i, tag, tte);
    end
    for (int n = 0; n < 400; n++) begin
      int unsigned j;
      logic [63:0] va, mk;
      j  = $urandom % 64;
      mk = size_mask(m_tte[j][62:61]);
      if (n % 16 == 0) ctx = 13'($urandom % 3);
      xlate_en = ($urandom % 16) != 0;
      if ($urandom % 8 == 0) va = {$urandom, $urandom};
      else va = (m_tag[j] & ~64'h1FFF) | ({$urandom, $urandom} & ~mk);
      do_lookup("R6", va, 1'($urandom), 1'($urandom), 1'($urandom % 20 == 0), 1'b0, '0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule